// File: doc/BRIEF.md
# Crypto Capability Table Matcher

This block keeps a small table of cipher capability entries and answers lookup requests against it. Each entry holds an algorithm code, a key-size code and a bitmask of the data-unit sizes it accepts. Software or a loader fills the entries through a write port and sets how many of them are live through a separate count write.

A lookup names an algorithm, a key-size code and a data-unit size in bytes. The block turns the size into a one-hot unit mask, where bit n stands for 512·2^n bytes. It then scans the live entries and reports the lowest-numbered entry that agrees on all three points. Only one request mode is searchable: algorithm code 0 (AES-XTS) with key-size code 3 (256-bit). A separate level input says whether crypto support exists at all. The response is registered and also carries the key length in bytes for the requested key-size code.

Top module: `capm_top`

## Requirements
- R1: After reset the live-entry count is zero and every entry is cleared, so every lookup misses; `rsp_valid` is low until a request is made.
- R2: A data-unit size gives the unit mask size/512 (bit n set for 512·2^n bytes) only when it is a power of two from 512 to 65536 bytes; any other size gives an empty mask, and the lookup misses.
- R3: An entry matches only if its algorithm code equals `req_alg`, its key-size code equals `req_ksz`, and its unit mask shares at least one set bit with the request mask.
- R4: When several entries match, `rsp_idx` is the lowest matching index.
- R5: Only indices below the live-entry count take part in a lookup. A count write above DEPTH is stored as DEPTH.
- R6: While `cap_present` is low, every lookup misses.
- R7: A lookup is carried out only for algorithm code 0 with key-size code 3. Any other pair misses even if an entry with exactly those codes exists.
- R8: `rsp_klen` gives the key length in bytes for the request's key-size code: code 1 gives 16, 2 gives 24, 3 gives 32 and 4 gives 64. Every other code gives 0.
- R9: `rsp_valid` is high for exactly the cycle after each cycle in which `req_valid` is high. `rsp_hit`, `rsp_idx` and `rsp_klen` hold their values while no request is made.
- R10: An entry write in the same cycle as a request does not affect that request. It affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_present | input | 1 | Crypto support exists; low forces misses |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_alg | input | 8 | Algorithm code for the written entry |
| wr_ksz | input | 8 | Key-size code for the written entry |
| wr_units | input | 8 | Unit-size mask for the written entry |
| cnt_we | input | 1 | Load the live-entry count |
| cnt_val | input | CNT_W | New live-entry count |
| req_valid | input | 1 | Lookup request strobe |
| req_alg | input | 8 | Requested algorithm code |
| req_ksz | input | 8 | Requested key-size code |
| req_size | input | 17 | Requested data-unit size in bytes |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | A matching entry was found |
| rsp_idx | output | IDX_W | Lowest matching entry index |
| rsp_klen | output | 7 | Key length in bytes for the request's key-size code |

## Verification
The hardest case to reach is an entry that matches but lies at or beyond the live-entry count, combined with a count write that gets clamped. To reach it, the stimulus places the only entry that can match a given size at the top index. It then moves the count below that index and afterwards writes an oversized count, and it expects a miss and then a hit. A second hard case is a write and a lookup in the same cycle. The stimulus clears the entry the lookup would hit in that very cycle, so the lookup must still see the old contents and the following lookup must not.

// File: rtl/capm_pkg.sv
package capm_pkg;
    localparam int ALG_W    = 8;
    localparam int KSZ_W    = 8;
    localparam int SIZE_W   = 17;
    localparam int UNIT_LOG = 9;
    localparam int MASK_W   = SIZE_W - UNIT_LOG;
    localparam int KLEN_W   = 7;

    localparam logic [ALG_W-1:0] ALG_XTS = '0;
    localparam logic [KSZ_W-1:0] KSZ_256 = KSZ_W'(3);

    typedef struct packed {
        logic [ALG_W-1:0]  alg;
        logic [KSZ_W-1:0]  ksz;
        logic [MASK_W-1:0] units;
    } cap_ent_t;

    function automatic logic [KLEN_W-1:0] key_bytes(input logic [KSZ_W-1:0] code);
        case (code)
            KSZ_W'(1): key_bytes = KLEN_W'(16);
            KSZ_W'(2): key_bytes = KLEN_W'(24);
            KSZ_W'(3): key_bytes = KLEN_W'(32);
            KSZ_W'(4): key_bytes = KLEN_W'(64);
            default:   key_bytes = '0;
        endcase
    endfunction
endpackage

// File: rtl/capm_unit_dec.sv
module capm_unit_dec
    import capm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SIZE_W-1:0] size_i,
    output logic [MASK_W-1:0] mask_o
);
    localparam logic [SIZE_W-1:0] MIN_SIZE = SIZE_W'(1) << UNIT_LOG;

    logic pow2;
    logic legal;

    always_comb begin
        pow2   = (size_i & (size_i - SIZE_W'(1))) == '0;
        legal  = pow2 && (size_i >= MIN_SIZE);
        mask_o = legal ? size_i[SIZE_W-1:UNIT_LOG] : '0;
    end

    // R2: a legal size selects exactly one unit bit, an illegal one none
    p_mask_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask_o));
endmodule

// File: rtl/capm_table.sv
module capm_table
    import capm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  cap_ent_t               wr_ent,
    input  logic                   cnt_we,
    input  logic [CNT_W-1:0]       cnt_val,
    output cap_ent_t [DEPTH-1:0]   ents_o,
    output logic [CNT_W-1:0]       count_o
);
    typedef struct packed {
        cap_ent_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]     cnt;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_idx) < DEPTH)) begin
            st_d.ent[wr_idx] = wr_ent;
        end
        if (cnt_we) begin
            st_d.cnt = (int'(cnt_val) > DEPTH) ? CNT_W'(DEPTH) : cnt_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ents_o  = st_q.ent;
    assign count_o = st_q.cnt;

    // R5: the live count never exceeds the table depth
    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        int'(count_o) <= DEPTH);
endmodule

// File: rtl/capm_search.sv
module capm_search
    import capm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cap_ent_t [DEPTH-1:0] ents_i,
    input  logic [CNT_W-1:0]     count_i,
    input  logic                 en_i,
    input  logic [ALG_W-1:0]     alg_i,
    input  logic [KSZ_W-1:0]     ksz_i,
    input  logic [MASK_W-1:0]    mask_i,
    output logic                 hit_o,
    output logic [IDX_W-1:0]     idx_o
);
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = (g < int'(count_i))
                       && (ents_i[g].alg == alg_i)
                       && (ents_i[g].ksz == ksz_i)
                       && ((ents_i[g].units & mask_i) != '0);
    end

    always_comb begin
        idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
        hit_o = en_i && (match != '0);
    end

    // R5: a reported entry always lies inside the live range
    p_hit_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (int'(idx_o) < int'(count_i)));
    // R3: a reported entry agrees with the request on algorithm and key size
    p_hit_fields_r3: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (ents_i[idx_o].alg == alg_i) && (ents_i[idx_o].ksz == ksz_i));
endmodule

// File: rtl/capm_top.sv
module capm_top
    import capm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_present,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ALG_W-1:0]  wr_alg,
    input  logic [KSZ_W-1:0]  wr_ksz,
    input  logic [MASK_W-1:0] wr_units,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              req_valid,
    input  logic [ALG_W-1:0]  req_alg,
    input  logic [KSZ_W-1:0]  req_ksz,
    input  logic [SIZE_W-1:0] req_size,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [KLEN_W-1:0] rsp_klen
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [KLEN_W-1:0] klen;
    } rsp_t;

    cap_ent_t [DEPTH-1:0] ents;
    cap_ent_t             wr_ent;
    logic [CNT_W-1:0]     count;
    logic [MASK_W-1:0]    req_mask;
    logic                 mode_ok;
    logic                 srch_hit;
    logic [IDX_W-1:0]     srch_idx;
    rsp_t                 rsp_d, rsp_q;

    assign wr_ent  = '{alg: wr_alg, ksz: wr_ksz, units: wr_units};
    assign mode_ok = cap_present && (req_alg == ALG_XTS) && (req_ksz == KSZ_256);

    capm_table #(.DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_ent  (wr_ent),
        .cnt_we  (cnt_we),
        .cnt_val (cnt_val),
        .ents_o  (ents),
        .count_o (count)
    );

    capm_unit_dec u_dec (
        .clk    (clk),
        .rst    (rst),
        .size_i (req_size),
        .mask_o (req_mask)
    );

    capm_search #(.DEPTH(DEPTH)) u_search (
        .clk     (clk),
        .rst     (rst),
        .ents_i  (ents),
        .count_i (count),
        .en_i    (mode_ok),
        .alg_i   (req_alg),
        .ksz_i   (req_ksz),
        .mask_i  (req_mask),
        .hit_o   (srch_hit),
        .idx_o   (srch_idx)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.hit  = srch_hit;
            rsp_d.idx  = srch_hit ? srch_idx : '0;
            rsp_d.klen = key_bytes(req_ksz);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_idx   = rsp_q.idx;
    assign rsp_klen  = rsp_q.klen;

    // R9: a response strobe follows every request, and only requests
    p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_single_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rsp_hit) && $stable(rsp_idx) && $stable(rsp_klen));
    // R6: no hit is reported without crypto support
    p_hit_needs_cap_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> $past(cap_present));
    // R7: hits come only from the single searchable mode
    p_hit_mode_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> ($past(req_alg) == ALG_XTS) && ($past(req_ksz) == KSZ_256));
endmodule

// File: tb/capm_top_test.sv
module capm_top_test;
    import capm_pkg::*;

    localparam int DEPTH = 8;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ALG_W-1:0]  alg;
        logic [KSZ_W-1:0]  ksz;
        logic [SIZE_W-1:0] size;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [KLEN_W-1:0] klen;
    } vec_t;

    localparam int NV = 14;
    // table: 0:{0,3,01} 1:{1,3,FF} 2:{0,2,FF} 3:{0,3,0A} 4:{0,3,FF} 5:{0,3,80}, count 6
    localparam vec_t VECS [NV] = '{
        '{8'd0, 8'd3, 17'd512,   1'b1, 3'd0, 7'd32},  // R3 R4
        '{8'd0, 8'd3, 17'd1024,  1'b1, 3'd3, 7'd32},  // R2 R4
        '{8'd0, 8'd3, 17'd4096,  1'b1, 3'd3, 7'd32},  // R2
        '{8'd0, 8'd3, 17'd2048,  1'b1, 3'd4, 7'd32},  // R3
        '{8'd0, 8'd3, 17'd65536, 1'b1, 3'd4, 7'd32},  // R2 upper bound
        '{8'd0, 8'd3, 17'd768,   1'b0, 3'd0, 7'd32},  // R2 not power of two
        '{8'd0, 8'd3, 17'd256,   1'b0, 3'd0, 7'd32},  // R2 below range
        '{8'd0, 8'd3, 17'd0,     1'b0, 3'd0, 7'd32},  // R2 zero
        '{8'd0, 8'd2, 17'd512,   1'b0, 3'd0, 7'd24},  // R7 R8
        '{8'd1, 8'd3, 17'd512,   1'b0, 3'd0, 7'd32},  // R7
        '{8'd0, 8'd1, 17'd512,   1'b0, 3'd0, 7'd16},  // R8
        '{8'd0, 8'd4, 17'd512,   1'b0, 3'd0, 7'd64},  // R8
        '{8'd0, 8'd5, 17'd512,   1'b0, 3'd0, 7'd0},   // R8 invalid code
        '{8'd0, 8'd0, 17'd512,   1'b0, 3'd0, 7'd0}    // R8 invalid code
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cap_present = 1'b1;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [ALG_W-1:0]  wr_alg = '0;
    logic [KSZ_W-1:0]  wr_ksz = '0;
    logic [MASK_W-1:0] wr_units = '0;
    logic              cnt_we = 1'b0;
    logic [CNT_W-1:0]  cnt_val = '0;
    logic              req_valid = 1'b0;
    logic [ALG_W-1:0]  req_alg = '0;
    logic [KSZ_W-1:0]  req_ksz = '0;
    logic [SIZE_W-1:0] req_size = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [IDX_W-1:0]  rsp_idx;
    logic [KLEN_W-1:0] rsp_klen;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    capm_top #(.DEPTH(DEPTH)) uut (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input int idx, input int alg, input int ksz, input int units);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_alg = ALG_W'(alg);
        wr_ksz = KSZ_W'(ksz); wr_units = MASK_W'(units);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_count(input int n);
        cnt_we = 1'b1; cnt_val = CNT_W'(n);
        @(posedge clk); #1;
        cnt_we = 1'b0;
    endtask

    task automatic ask(input int alg, input int ksz, input int size);
        req_valid = 1'b1; req_alg = ALG_W'(alg);
        req_ksz = KSZ_W'(ksz); req_size = SIZE_W'(size);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 rsp_valid idle after reset", int'(rsp_valid), 0);
        ask(0, 3, 512);
        check("R1 empty table misses", int'(rsp_hit), 0);
        check("R9 response strobe", int'(rsp_valid), 1);

        put(0, 0, 3, 'h01);
        put(1, 1, 3, 'hFF);
        put(2, 0, 2, 'hFF);
        put(3, 0, 3, 'h0A);
        put(4, 0, 3, 'hFF);
        put(5, 0, 3, 'h80);
        ask(0, 3, 512);
        check("R5 count zero hides entries", int'(rsp_hit), 0);
        set_count(6);

        for (int v = 0; v < NV; v++) begin
            ask(int'(VECS[v].alg), int'(VECS[v].ksz), int'(VECS[v].size));
            check($sformatf("R3 vector %0d hit", v), int'(rsp_hit), int'(VECS[v].hit));
            if (VECS[v].hit) check($sformatf("R4 vector %0d idx", v), int'(rsp_idx), int'(VECS[v].idx));
            check($sformatf("R8 vector %0d klen", v), int'(rsp_klen), int'(VECS[v].klen));
        end

        // R9: strobe lasts one cycle, fields hold
        @(posedge clk); #1;
        check("R9 strobe drops", int'(rsp_valid), 0);
        check("R9 klen held", int'(rsp_klen), 0);

        // R5: live range and count clamp
        put(4, 0, 3, 'h40);
        put(7, 0, 3, 'h20);
        ask(0, 3, 16384);
        check("R5 entry beyond count ignored", int'(rsp_hit), 0);
        set_count(15);
        ask(0, 3, 16384);
        check("R5 clamped count hit", int'(rsp_hit), 1);
        check("R5 clamped count idx", int'(rsp_idx), 7);
        set_count(5);
        ask(0, 3, 65536);
        check("R5 count 5 excludes idx5", int'(rsp_hit), 0);
        set_count(6);
        ask(0, 3, 65536);
        check("R5 count 6 includes idx5", int'(rsp_idx), 5);

        // R6: no support
        cap_present = 1'b0;
        ask(0, 3, 512);
        check("R6 no support misses", int'(rsp_hit), 0);
        cap_present = 1'b1;

        // R10: write and lookup in the same cycle
        wr_en = 1'b1; wr_idx = 3'd0; wr_alg = '0; wr_ksz = KSZ_W'(3); wr_units = '0;
        ask(0, 3, 512);
        wr_en = 1'b0;
        check("R10 same-cycle write unseen hit", int'(rsp_hit), 1);
        check("R10 same-cycle write unseen idx", int'(rsp_idx), 0);
        ask(0, 3, 512);
        check("R10 write seen later", int'(rsp_hit), 0);

        // R1: reset clears table and count
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        check("R1 rsp cleared", int'(rsp_valid), 0);
        set_count(8);
        ask(0, 3, 65536);
        check("R1 entries cleared", int'(rsp_hit), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule